// File: doc/BRIEF.md
# Ethernet Transmit Error Sequencer

This block is the transmit-side controller of a 10/100 Ethernet MAC. It reads frame bytes from a transmit FIFO over a valid/ready stream and puts them on a 4-bit media-independent transmit path. Each frame starts with a preamble and start delimiter, carries its data low nibble first and ends with a CRC-32 frame check sequence. One clock cycle is one nibble time.

While a frame is on the wire, the block watches for three failures: the FIFO running dry, a collision, and running out of retransmission attempts. An early collision (before the slot time) causes a jam, a fixed backoff, a rewind of the FIFO to the start of the frame and a retransmission. A late collision ends the frame at once. An underrun closes the frame with a deliberately wrong check sequence. In every case the block records a sticky event flag. It then drains whatever is left of the aborted frame, pulses the next-descriptor strobe and picks up the following frame without any software step. The flags reach a single interrupt line through a mask.

The stream rules are as follows. `fifo_ready` is raised only in two cases: when a new data byte is needed (every second nibble of the data phase, and never in a cycle with a collision) and while an aborted frame is being drained. A byte moves on a cycle where both `fifo_ready` and `fifo_valid` are high. In the data phase the FIFO must keep `fifo_valid` high while it still holds bytes of the frame. If `fifo_valid` is low while `fifo_ready` is high in the data phase, the block treats it as an underrun. `fifo_valid` in the idle state starts a frame. `fifo_rewind` tells the FIFO to move its read point back to the first byte of the current frame.

Top module: `eth_tx_err_seq`

## Requirements
- R1: A frame is sent as follows. First PRE_NIBBLES-1 nibbles of 0x5, then one of 0xD. Next, each accepted byte goes out low nibble first. Last come 8 nibbles of the frame check sequence, low nibble first. The check sequence is the complement of a reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) over the data bytes. `mii_tx_en` is high for exactly these nibbles.
- R2: If `fifo_valid` is low when a data byte is needed, the block sends 8 more nibbles and then drops `mii_tx_en`. These nibbles are the bitwise inverse of the check sequence of the bytes accepted so far, low nibble first. It also sets event flag bit 0 (underrun).
- R3: After any frame (complete or aborted), bytes of that frame still in the FIFO are consumed up to and including the one marked `fifo_last`. Then `desc_next` pulses for one cycle and the next frame starts from the FIFO with no other input.
- R4: Nibble index 0 is the first preamble nibble. A collision seen while a frame nibble with index below SLOT_NIBBLES is on the wire gives 8 jam nibbles of 0xA. Then `mii_tx_en` drops, BACKOFF_CYCLES cycles pass, `fifo_rewind` pulses and the frame is sent again from its preamble.
- R5: A collision seen while a frame nibble with index SLOT_NIBBLES or higher is on the wire drops `mii_tx_en` in the next cycle with no jam, and sets event flag bit 1 (late collision).
- R6: The MAX_ATTEMPTS-th early collision of a frame ends that frame after its jam with no retransmission and sets event flag bit 2 (retry limit). The frame has had MAX_ATTEMPTS-1 rewinds.
- R7: `irq` is high exactly when some event flag is set whose bit in the mask register is also set. The mask is written whole by `mask_we`/`mask_wdata` and is zero after reset.
- R8: Event flags are sticky. A flag is cleared by `evt_clr_we` with a 1 in its bit of `evt_clr`. If a clear and a new event on the same flag fall in the same cycle, the flag stays set.
- R9: After reset and while idle with no data offered, `mii_tx_en`, `fifo_ready`, `desc_next`, `evt_flags` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_data | input | 8 | Frame byte from transmit FIFO |
| fifo_last | input | 1 | Marks the final byte of a frame |
| fifo_valid | input | 1 | FIFO has a byte on fifo_data |
| fifo_ready | output | 1 | Block takes the byte this cycle if valid |
| fifo_rewind | output | 1 | Move FIFO read point back to frame start |
| mii_col | input | 1 | Collision indication from the PHY |
| mii_tx_en | output | 1 | Transmit enable |
| mii_txd | output | 4 | Transmit nibble |
| desc_next | output | 1 | One-cycle strobe: advance to next descriptor |
| evt_clr_we | input | 1 | Write strobe for flag clear |
| evt_clr | input | 3 | Write-1-to-clear mask for event flags |
| mask_we | input | 1 | Write strobe for interrupt mask |
| mask_wdata | input | 3 | New interrupt mask value |
| evt_flags | output | 3 | Sticky flags: bit0 underrun, bit1 late collision, bit2 retry limit |
| irq | output | 1 | Masked OR of event flags |

## Verification
The bench keeps the 128-nibble slot so that it can probe the exact boundary. A collision is placed on nibble 127 in one frame and on nibble 128 in another, and the two must end up on opposite sides of the late-collision decision. MAX_ATTEMPTS is set to 3 and BACKOFF_CYCLES to 20, so the retry-limit abort is reached within a few hundred cycles, after two rewinds. With these values, late collisions in the last data nibble and in the check sequence are also within reach, as are a collision inside the preamble and an underrun after the very first byte.

// File: rtl/eth_tx_seq_pkg.sv
package eth_tx_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_DATA, ST_FCS, ST_TAIL,
    ST_JAM, ST_BACKOFF, ST_DRAIN, ST_NEXT
  } tx_state_e;

  localparam int EV_W       = 3;
  localparam int EV_UNDERRUN = 0;
  localparam int EV_LATE    = 1;
  localparam int EV_RETRY   = 2;

  localparam logic [3:0] NIB_PRE = 4'h5;
  localparam logic [3:0] NIB_SFD = 4'hD;
  localparam logic [3:0] NIB_JAM = 4'hA;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  function automatic logic [31:0] crc32_step(input logic [31:0] c_in,
                                             input logic [7:0]  d);
    logic [31:0] c;
    c = c_in ^ {24'd0, d};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32
  import eth_tx_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  data,
  output logic [31:0] crc
);

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (init) crc_q <= CRC_SEED;
    else if (upd)  crc_q <= crc32_step(crc_q, data);
  end

  assign crc = crc_q;

endmodule

// File: rtl/eth_tx_evt_regs.sv
module eth_tx_evt_regs
  import eth_tx_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_set,
  input  logic            clr_we,
  input  logic [EV_W-1:0] clr,
  input  logic            mask_we,
  input  logic [EV_W-1:0] mask_wdata,
  output logic [EV_W-1:0] flags,
  output logic            irq
);

  logic [EV_W-1:0] flag_q;
  logic [EV_W-1:0] mask_q;

  for (genvar i = 0; i < EV_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[i] <= 1'b0;
      else if (ev_set[i]) flag_q[i] <= 1'b1;
      else if (clr_we && clr[i]) flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & mask_q);

  // R8: an event always leaves its flag set, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((flags & $past(ev_set)) == $past(ev_set)));

  // R7: with a zero mask no flag reaches the interrupt
  p_mask_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

endmodule

// File: rtl/eth_tx_err_seq.sv
module eth_tx_err_seq
  import eth_tx_seq_pkg::*;
#(
  parameter int SLOT_NIBBLES   = 128,
  parameter int MAX_ATTEMPTS   = 16,
  parameter int BACKOFF_CYCLES = 64,
  parameter int PRE_NIBBLES    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      fifo_data,
  input  logic            fifo_last,
  input  logic            fifo_valid,
  output logic            fifo_ready,
  output logic            fifo_rewind,
  input  logic            mii_col,
  output logic            mii_tx_en,
  output logic [3:0]      mii_txd,
  output logic            desc_next,
  input  logic            evt_clr_we,
  input  logic [EV_W-1:0] evt_clr,
  input  logic            mask_we,
  input  logic [EV_W-1:0] mask_wdata,
  output logic [EV_W-1:0] evt_flags,
  output logic            irq
);

  localparam int CNT_MAX = (BACKOFF_CYCLES > PRE_NIBBLES) ? BACKOFF_CYCLES : PRE_NIBBLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int SLOT_W  = $clog2(SLOT_NIBBLES + 1);
  localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [CNT_W-1:0]  PRE_END  = CNT_W'(PRE_NIBBLES - 1);
  localparam logic [CNT_W-1:0]  BO_END   = CNT_W'(BACKOFF_CYCLES - 1);
  localparam logic [CNT_W-1:0]  WORD_END = CNT_W'(7);
  localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(SLOT_NIBBLES);
  localparam logic [ATT_W-1:0]  ATT_LIM  = ATT_W'(MAX_ATTEMPTS);

  tx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q;
  logic [ATT_W-1:0]  att_q, att_d;
  logic [3:0]        hold_q, hold_d;
  logic              nib_hi_q, nib_hi_d;
  logic              last_q, last_d;
  logic              txen_q, txen_d;
  logic [3:0]        txd_q, txd_d;
  logic              inf_q, inf_d;
  logic              crc_init, crc_upd;
  logic [31:0]       crc_raw;
  logic [EV_W-1:0]   ev_set;
  logic              coll_hit, late;
  logic [4:0]        nib_pos;

  eth_tx_crc32 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (crc_init),
    .upd  (crc_upd),
    .data (fifo_data),
    .crc  (crc_raw)
  );

  eth_tx_evt_regs u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_set    (ev_set),
    .clr_we    (evt_clr_we),
    .clr       (evt_clr),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .flags     (evt_flags),
    .irq       (irq)
  );

  assign coll_hit = mii_col && inf_q;
  assign late     = (slot_q >= SLOT_LIM);
  assign nib_pos  = {cnt_q[2:0], 2'b00};

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    att_d      = att_q;
    hold_d     = hold_q;
    nib_hi_d   = nib_hi_q;
    last_d     = last_q;
    txen_d     = 1'b0;
    txd_d      = 4'h0;
    inf_d      = 1'b0;
    fifo_ready = 1'b0;
    fifo_rewind = 1'b0;
    desc_next  = 1'b0;
    crc_init   = 1'b0;
    crc_upd    = 1'b0;
    ev_set     = '0;

    if (coll_hit) begin
      if (late) begin
        ev_set[EV_LATE] = 1'b1;
        st_d = last_q ? ST_NEXT : ST_DRAIN;
      end else begin
        att_d  = att_q + 1'b1;
        txen_d = 1'b1;
        txd_d  = NIB_JAM;
        cnt_d  = CNT_W'(1);
        st_d   = ST_JAM;
      end
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (fifo_valid) begin
            txen_d   = 1'b1;
            txd_d    = NIB_PRE;
            inf_d    = 1'b1;
            cnt_d    = CNT_W'(1);
            nib_hi_d = 1'b0;
            last_d   = 1'b0;
            crc_init = 1'b1;
            st_d     = ST_PRE;
          end
        end
        ST_PRE: begin
          txen_d = 1'b1;
          inf_d  = 1'b1;
          txd_d  = (cnt_q == PRE_END) ? NIB_SFD : NIB_PRE;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == PRE_END) st_d = ST_DATA;
        end
        ST_DATA: begin
          if (nib_hi_q) begin
            txen_d   = 1'b1;
            inf_d    = 1'b1;
            txd_d    = hold_q;
            nib_hi_d = 1'b0;
            if (last_q) begin
              cnt_d = '0;
              st_d  = ST_FCS;
            end
          end else begin
            fifo_ready = 1'b1;
            txen_d     = 1'b1;
            if (fifo_valid) begin
              inf_d    = 1'b1;
              txd_d    = fifo_data[3:0];
              hold_d   = fifo_data[7:4];
              last_d   = fifo_last;
              nib_hi_d = 1'b1;
              crc_upd  = 1'b1;
            end else begin
              txd_d = crc_raw[3:0];
              cnt_d = CNT_W'(1);
              st_d  = ST_TAIL;
            end
          end
        end
        ST_FCS: begin
          txen_d = 1'b1;
          inf_d  = 1'b1;
          txd_d  = ~crc_raw[nib_pos +: 4];
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == WORD_END) st_d = ST_NEXT;
        end
        ST_TAIL: begin
          txen_d = 1'b1;
          txd_d  = crc_raw[nib_pos +: 4];
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == WORD_END) begin
            ev_set[EV_UNDERRUN] = 1'b1;
            st_d = last_q ? ST_NEXT : ST_DRAIN;
          end
        end
        ST_JAM: begin
          txen_d = 1'b1;
          txd_d  = NIB_JAM;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == WORD_END) begin
            cnt_d = '0;
            if (att_q == ATT_LIM) begin
              ev_set[EV_RETRY] = 1'b1;
              st_d = last_q ? ST_NEXT : ST_DRAIN;
            end else begin
              st_d = ST_BACKOFF;
            end
          end
        end
        ST_BACKOFF: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == BO_END) begin
            fifo_rewind = 1'b1;
            st_d        = ST_IDLE;
          end
        end
        ST_DRAIN: begin
          fifo_ready = 1'b1;
          if (fifo_valid && fifo_last) st_d = ST_NEXT;
        end
        ST_NEXT: begin
          desc_next = 1'b1;
          att_d     = '0;
          st_d      = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      att_q    <= '0;
      hold_q   <= '0;
      nib_hi_q <= 1'b0;
      last_q   <= 1'b0;
      txen_q   <= 1'b0;
      txd_q    <= '0;
      inf_q    <= 1'b0;
      slot_q   <= '0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      att_q    <= att_d;
      hold_q   <= hold_d;
      nib_hi_q <= nib_hi_d;
      last_q   <= last_d;
      txen_q   <= txen_d;
      txd_q    <= txd_d;
      inf_q    <= inf_d;
      if (st_q == ST_IDLE)                   slot_q <= '0;
      else if (txen_q && slot_q != SLOT_LIM) slot_q <= slot_q + 1'b1;
    end
  end

  assign mii_tx_en = txen_q;
  assign mii_txd   = txd_q;

  // R1: an accepted byte shows its low nibble on the wire next cycle
  p_fetch_emit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ready && fifo_valid && st_q == ST_DATA)
      |=> (mii_tx_en && mii_txd == $past(fifo_data[3:0])));

  // R5: a late collision silences the line at once
  p_late_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_col && inf_q && late) |=> !mii_tx_en);

  // R4: the FIFO is rewound only while the line is quiet
  p_rewind_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rewind |-> (!mii_tx_en && !fifo_ready));

  // R3: the descriptor strobe is a single-cycle pulse
  p_desc_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_next |=> !desc_next);

  // R6: the attempt count never passes its limit
  p_att_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= ATT_LIM);

endmodule

// File: tb/eth_tx_err_seq_bench.sv
module eth_tx_err_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT  = 128;
  localparam int MAXA  = 3;
  localparam int BOFF  = 20;
  localparam int ROWS  = 8;
  localparam int WDOG  = 150000;

  // stimulus: length, collision nibble (-1 none), bytes available (-1 all)
  // expected: flags, nibbles on the wire
  localparam int T_LEN [ROWS] = '{10, 1, 64, 64, 20, 20, 64, 8};
  localparam int T_COL [ROWS] = '{-1, -1, 128, 127, 5, -1, 143, -1};
  localparam int T_CUT [ROWS] = '{-1, -1, -1, -1, -1, 6, -1, 1};
  localparam int T_FLG [ROWS] = '{0, 0, 2, 4, 4, 1, 2, 1};
  localparam int T_NIB [ROWS] = '{44, 26, 129, 408, 42, 36, 144, 26};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fifo_data;
  logic       fifo_last, fifo_valid, fifo_ready, fifo_rewind;
  logic       mii_col = 1'b0;
  logic       mii_tx_en, desc_next, irq;
  logic [3:0] mii_txd;
  logic       evt_clr_we = 1'b0;
  logic [2:0] evt_clr = 3'd0;
  logic       mask_we = 1'b0;
  logic [2:0] mask_wdata = 3'd0;
  logic [2:0] evt_flags;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit tmo = 1'b0;

  logic [8:0] mem [0:2047];
  int wr = 0, rd = 0, avail = 0, fbase = 0;
  logic [3:0] cap [0:1023];
  int ncap = 0, wpos = 0, col_at = -1, n_desc = 0, n_rew = 0;
  bit clr_on_col = 1'b0, clr_req = 1'b0;
  logic [2:0] clr_val = 3'd0;
  logic [3:0] expn [0:1023];
  int nexp = 0;

  eth_tx_err_seq #(.SLOT_NIBBLES(SLOT), .MAX_ATTEMPTS(MAXA),
                   .BACKOFF_CYCLES(BOFF), .PRE_NIBBLES(16)) u_eth_tx_err_seq (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_rewind(fifo_rewind),
    .mii_col(mii_col), .mii_tx_en(mii_tx_en), .mii_txd(mii_txd),
    .desc_next(desc_next), .evt_clr_we(evt_clr_we), .evt_clr(evt_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .evt_flags(evt_flags), .irq(irq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign fifo_valid = (rd < avail);
  assign fifo_data  = mem[rd[10:0]][7:0];
  assign fifo_last  = mem[rd[10:0]][8];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_rewind) rd <= fbase;
    else if (fifo_ready && fifo_valid) rd <= rd + 1;
  end

  always @(negedge clk) begin
    bit hit;
    hit = 1'b0;
    if (mii_tx_en) begin
      if (ncap < 1024) cap[ncap] = mii_txd;
      ncap++;
      hit = (wpos == col_at);
      wpos++;
    end else begin
      wpos = 0;
    end
    mii_col    = hit;
    evt_clr_we = clr_req || (clr_on_col && hit);
    evt_clr    = clr_req ? clr_val : 3'b010;
    clr_req    = 1'b0;
    if (desc_next)   n_desc++;
    if (fifo_rewind) n_rew++;
    if (cyc > WDOG) tmo = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int r, input int i);
    return 8'((r * 37 + i * 11 + 3) & 255);
  endfunction

  function automatic logic [31:0] crc_of(input int r, input int n);
    logic [31:0] c;
    logic [7:0]  d;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      d = byte_of(r, i);
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ d[b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  task automatic build_exp(input int r);
    logic [3:0]  f [0:1023];
    int          fn, nb, att, c;
    logic [31:0] w;
    fn = 0;
    for (int i = 0; i < 15; i++) begin f[fn] = 4'h5; fn++; end
    f[fn] = 4'hD; fn++;
    nb = (T_CUT[r] >= 0) ? T_CUT[r] : T_LEN[r];
    for (int i = 0; i < nb; i++) begin
      f[fn] = byte_of(r, i) >> 0; f[fn] = byte_of(r, i) & 8'h0F; fn++;
      f[fn] = 4'(byte_of(r, i) >> 4); fn++;
    end
    w = crc_of(r, nb);
    if (T_CUT[r] < 0) w = ~w;
    for (int k = 0; k < 8; k++) begin f[fn] = 4'(w >> (4 * k)); fn++; end
    nexp = 0;
    c = T_COL[r];
    if (c < 0) begin
      for (int i = 0; i < fn; i++) begin expn[nexp] = f[i]; nexp++; end
    end else if (c >= SLOT) begin
      for (int i = 0; i <= c; i++) begin expn[nexp] = f[i]; nexp++; end
    end else begin
      for (att = 0; att < MAXA; att++) begin
        for (int i = 0; i <= c; i++) begin expn[nexp] = f[i]; nexp++; end
        for (int k = 0; k < 8; k++) begin expn[nexp] = 4'hA; nexp++; end
      end
    end
  endtask

  function automatic string req_of(input int r);
    if (T_CUT[r] >= 0) return "R2";
    if (T_COL[r] < 0) return "R1";
    if (T_COL[r] >= SLOT) return "R5";
    return "R6";
  endfunction

  task automatic run_row(input int r, input bit set_clr);
    int d0, rw0, bad, lim;
    build_exp(r);
    fbase = wr;
    for (int i = 0; i < T_LEN[r]; i++) begin
      mem[wr[10:0]] = {(i == T_LEN[r] - 1), byte_of(r, i)};
      wr++;
    end
    ncap = 0; d0 = n_desc; rw0 = n_rew;
    col_at = T_COL[r];
    clr_on_col = set_clr;
    avail = (T_CUT[r] >= 0) ? fbase + T_CUT[r] : wr;
    while (n_desc == d0 && !tmo) begin
      @(negedge clk);
      if (T_CUT[r] >= 0 && evt_flags[0]) avail = wr;
    end
    repeat (3) @(negedge clk);
    col_at = -1; clr_on_col = 1'b0;
    bad = 0;
    lim = (ncap < nexp) ? ncap : nexp;
    for (int i = 0; i < lim; i++) if (cap[i] !== expn[i]) bad++;
    check({req_of(r), " nibble count"}, ncap, T_NIB[r]);
    check({req_of(r), " nibble content"}, bad, 0);
    check(set_clr ? "R8 set wins over clear" : {req_of(r), " flags"},
          int'(evt_flags), T_FLG[r]);
    check("R3 frame drained", rd, wr);
    check("R3 one descriptor strobe", n_desc - d0, 1);
    check("R4 rewinds", n_rew - rw0, (T_COL[r] >= 0 && T_COL[r] < SLOT) ? MAXA - 1 : 0);
    check("R7 irq with full mask", int'(irq), int'(T_FLG[r] != 0));
  endtask

  task automatic clear_flags(input logic [2:0] v);
    clr_val = v; clr_req = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic set_mask(input logic [2:0] v);
    mask_wdata = v; mask_we = 1'b1;
    @(negedge clk); mask_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: quiet after reset
    check("R9 tx_en after reset", int'(mii_tx_en), 0);
    check("R9 ready when idle", int'(fifo_ready), 0);
    check("R9 desc_next idle", int'(desc_next), 0);
    check("R9 flags after reset", int'(evt_flags), 0);
    check("R9 irq after reset", int'(irq), 0);

    set_mask(3'b111);
    for (int r = 0; r < ROWS && !tmo; r++) begin
      run_row(r, 1'b0);
      clear_flags(3'b111);
      check("R8 write-1 clears", int'(evt_flags), 0);
      check("R9 ready idle between frames", int'(fifo_ready), 0);
    end

    // R8: clear lands in the same cycle as the late-collision event
    if (!tmo) run_row(2, 1'b1);

    // R7: mask selects which flags raise irq (flag bit1 is set here)
    set_mask(3'b101);
    check("R7 masked flag gives no irq", int'(irq), 0);
    set_mask(3'b010);
    check("R7 unmasked flag raises irq", int'(irq), 1);
    clear_flags(3'b101);
    check("R8 clear of other bits keeps flag", int'(evt_flags), 2);
    clear_flags(3'b010);
    check("R7 irq drops after clear", int'(irq), 0);

    if (tmo) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule